// File: doc/BRIEF.md
# Multi-Zone Lookup Fan Speed Selector

This block turns several temperature readings into one fan command. Each channel has its own table of ascending temperature thresholds, a hysteresis value, and a setting for every threshold. Each setting is either a PWM duty value or a tachometer target count. Every channel keeps a current table level. The level rises when the temperature reaches a higher threshold. It falls only when the temperature drops below the current threshold by more than the hysteresis.

Nothing is recomputed while temperatures change. The levels and outputs update only when a conversion-done strobe arrives. In direct mode the hottest demand wins, which is the largest duty among the channels. In closed-loop mode the fastest demand wins, which is the smallest tach count; the duty output is then left to an external speed loop. When every channel has fallen back to level zero, the fan is switched off.

Top module: `fzs_fan_selector`

## Requirements
- R1: Channel levels and all outputs change only on the clock edge where `conv_done` is high; on all other edges they hold their values.
- R2: For a channel at level L (0..NLVL), a conversion whose temperature is at or above threshold L (zero-based, `thr_tab` entry L of that channel) raises the level. Thresholds must be strictly ascending within a channel.
- R3: With no rise, a channel at level L > 0 drops when its temperature is below threshold L-1 minus its hysteresis. The subtraction saturates at 0, so a threshold below the hysteresis can never be left.
- R4: In direct mode (`mode_rpm` = 0) with at least one channel above level 0, `duty_out` becomes the largest `duty_tab` entry (level-1) over the channels above level 0, and `tach_target` holds.
- R5: In closed-loop mode (`mode_rpm` = 1) with at least one channel above level 0, `tach_target` becomes the smallest `tach_tab` entry (level-1) over the channels above level 0.
- R6: In closed-loop mode the table never drives `duty_out`: it keeps its previous value, except that a shutdown forces it to 0.
- R7: When a conversion leaves every channel at level 0, `duty_out` becomes 0 and `fan_en` goes low; `tach_target` holds.
- R8: `fan_en` returns high on the first conversion in which any channel is above level 0.
- R9: Synchronous reset clears all channel levels, sets `duty_out` to 0, `fan_en` to 0 and `tach_target` to all ones.
- R10: One conversion may move a channel across several levels, up or down, to where its temperature now settles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: new temperatures are valid |
| mode_rpm | input | 1 | 0 = direct duty, 1 = closed-loop tach target |
| temp_in | input | NCH*TW | Channel temperatures, channel 0 in the low bits |
| thr_tab | input | NCH*NLVL*TW | Thresholds, entry (ch*NLVL+k) at bits k-major per channel |
| hyst_tab | input | NCH*TW | Per-channel hysteresis |
| duty_tab | input | NCH*NLVL*DW | Per-channel duty settings, same layout as thresholds |
| tach_tab | input | NCH*NLVL*CW | Per-channel tach count settings, same layout |
| duty_out | output | DW | Registered PWM duty command |
| tach_target | output | CW | Registered tach target count |
| fan_en | output | 1 | Fan enable |

## Verification
On every cycle, the assertions check the following: levels and outputs stay stable between strobes; a level always rises when the next threshold is met and never falls while the temperature stays within the hysteresis band; a disabled fan always has zero duty; the duty holds in closed-loop mode; and the tach target holds in direct mode. Only the bench's scenarios can show that the merged values are the correct maximum or minimum among the channels. They also show that shutdown happens only when every channel is low, and that multi-level jumps land on the right entry. The bench shows these through up and down temperature ramps in both modes and through pseudo-random mixes of temperatures.

// File: rtl/fzs_pkg.sv
`timescale 1ns/1ps
package fzs_pkg;

    typedef enum logic {
        FAN_DIRECT = 1'b0,
        FAN_RPM    = 1'b1
    } fan_mode_e;

    // width of a level counter able to hold 0..n
    function automatic int lvl_width(input int n);
        return $clog2(n + 1);
    endfunction

    // width of an index into n entries, at least 1
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fzs_zone_tracker.sv
`timescale 1ns/1ps
module fzs_zone_tracker #(
    parameter int NLVL = 8,
    parameter int TW   = 8,
    localparam int LW  = fzs_pkg::lvl_width(NLVL),
    localparam int IW  = fzs_pkg::idx_width(NLVL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               conv_done,
    input  logic [TW-1:0]      temp,
    input  logic [NLVL*TW-1:0] thr_row,
    input  logic [TW-1:0]      hyst,
    output logic [LW-1:0]      lvl_q,
    output logic [LW-1:0]      lvl_nxt
);

    logic [TW-1:0] thr_a     [NLVL];
    logic [TW-1:0] thr_low_a [NLVL];
    logic [LW-1:0] up_cnt;
    logic [LW-1:0] hold_cnt;

    for (genvar g = 0; g < NLVL; g++) begin : g_entry
        assign thr_a[g]     = thr_row[g*TW +: TW];
        assign thr_low_a[g] = (thr_a[g] > hyst) ? (thr_a[g] - hyst) : '0;
    end

    // count thresholds met, and thresholds whose lowered bound is met
    always_comb begin
        up_cnt   = '0;
        hold_cnt = '0;
        for (int k = 0; k < NLVL; k++) begin
            if (temp >= thr_a[k])     up_cnt   = up_cnt + LW'(1);
            if (temp >= thr_low_a[k]) hold_cnt = hold_cnt + LW'(1);
        end
    end

    always_comb begin
        if (up_cnt > lvl_q)        lvl_nxt = up_cnt;
        else if (hold_cnt < lvl_q) lvl_nxt = hold_cnt;
        else                       lvl_nxt = lvl_q;
    end

    always_ff @(posedge clk) begin
        if (rst)            lvl_q <= '0;
        else if (conv_done) lvl_q <= lvl_nxt;
    end

    // helpers for the checks below
    logic          has_next;
    logic          has_cur;
    logic [TW-1:0] thr_next;
    logic [TW-1:0] low_cur;
    logic          asc_ok;

    always_comb begin
        has_next = (lvl_q < LW'(NLVL));
        has_cur  = (lvl_q != '0);
        thr_next = has_next ? thr_a[lvl_q[IW-1:0]] : '1;
        low_cur  = has_cur ? thr_low_a[IW'(lvl_q - LW'(1))] : '0;
        asc_ok   = 1'b1;
        for (int k = 1; k < NLVL; k++) begin
            if (thr_a[k] <= thr_a[k-1]) asc_ok = 1'b0;
        end
    end

    // R2
    thr_order_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> asc_ok);

    // R2
    lvl_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && has_next && temp >= thr_next) |=> (lvl_q > $past(lvl_q)));

    // R3
    lvl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && has_cur && temp >= low_cur) |=> (lvl_q >= $past(lvl_q)));

    // R3
    lvl_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && has_cur && temp < low_cur) |=> (lvl_q < $past(lvl_q)));

    // R1
    lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(lvl_q));

endmodule

// File: rtl/fzs_merge.sv
`timescale 1ns/1ps
module fzs_merge #(
    parameter int NCH  = 4,
    parameter int NLVL = 8,
    parameter int DW   = 8,
    parameter int CW   = 16,
    localparam int LW  = fzs_pkg::lvl_width(NLVL)
) (
    input  logic [NCH*LW-1:0]      lvl_flat,
    input  logic [NCH*NLVL*DW-1:0] duty_tab,
    input  logic [NCH*NLVL*CW-1:0] tach_tab,
    output logic                   any_on,
    output logic [DW-1:0]          duty_max,
    output logic [CW-1:0]          tach_min
);

    always_comb begin
        any_on   = 1'b0;
        duty_max = '0;
        tach_min = '1;
        for (int ch = 0; ch < NCH; ch++) begin
            logic [LW-1:0] lv;
            logic [DW-1:0] d;
            logic [CW-1:0] t;
            int            idx;
            lv  = lvl_flat[ch*LW +: LW];
            idx = (lv != '0) ? (ch*NLVL + int'(lv) - 1) : ch*NLVL;
            d   = duty_tab[idx*DW +: DW];
            t   = tach_tab[idx*CW +: CW];
            if (lv != '0) begin
                any_on = 1'b1;
                if (d > duty_max) duty_max = d;
                if (t < tach_min) tach_min = t;
            end
        end
    end

endmodule

// File: rtl/fzs_fan_selector.sv
`timescale 1ns/1ps
module fzs_fan_selector #(
    parameter int NCH  = 4,
    parameter int NLVL = 8,
    parameter int TW   = 8,
    parameter int DW   = 8,
    parameter int CW   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   conv_done,
    input  logic                   mode_rpm,
    input  logic [NCH*TW-1:0]      temp_in,
    input  logic [NCH*NLVL*TW-1:0] thr_tab,
    input  logic [NCH*TW-1:0]      hyst_tab,
    input  logic [NCH*NLVL*DW-1:0] duty_tab,
    input  logic [NCH*NLVL*CW-1:0] tach_tab,
    output logic [DW-1:0]          duty_out,
    output logic [CW-1:0]          tach_target,
    output logic                   fan_en
);
    import fzs_pkg::*;

    localparam int LW = lvl_width(NLVL);

    fan_mode_e         mode;
    logic [NCH*LW-1:0] lvl_cur;
    logic [NCH*LW-1:0] lvl_next;
    logic              any_on;
    logic [DW-1:0]     duty_max;
    logic [CW-1:0]     tach_min;

    assign mode = fan_mode_e'(mode_rpm);

    for (genvar c = 0; c < NCH; c++) begin : g_zone
        fzs_zone_tracker #(.NLVL(NLVL), .TW(TW)) zone_i (
            .clk       (clk),
            .rst       (rst),
            .conv_done (conv_done),
            .temp      (temp_in[c*TW +: TW]),
            .thr_row   (thr_tab[c*NLVL*TW +: NLVL*TW]),
            .hyst      (hyst_tab[c*TW +: TW]),
            .lvl_q     (lvl_cur[c*LW +: LW]),
            .lvl_nxt   (lvl_next[c*LW +: LW])
        );
    end

    fzs_merge #(.NCH(NCH), .NLVL(NLVL), .DW(DW), .CW(CW)) merge_i (
        .lvl_flat (lvl_next),
        .duty_tab (duty_tab),
        .tach_tab (tach_tab),
        .any_on   (any_on),
        .duty_max (duty_max),
        .tach_min (tach_min)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_out    <= '0;
            tach_target <= '1;
            fan_en      <= 1'b0;
        end else if (conv_done) begin
            if (!any_on) begin
                duty_out <= '0;
                fan_en   <= 1'b0;
            end else begin
                fan_en <= 1'b1;
                if (mode == FAN_RPM) tach_target <= tach_min;
                else                 duty_out    <= duty_max;
            end
        end
    end

    // R9
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (!fan_en && duty_out == '0 && tach_target == '1));

    // R7
    off_duty_chk: assert property (@(posedge clk) disable iff (rst)
        !fan_en |-> (duty_out == '0));

    // R1
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> ($stable(duty_out) && $stable(tach_target) && $stable(fan_en)));

    // R6
    rpm_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && mode == FAN_RPM) |=> (duty_out == $past(duty_out) || duty_out == '0));

    // R4
    direct_tach_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && mode == FAN_DIRECT) |=> $stable(tach_target));

    // R8
    enable_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && lvl_next != '0) |=> fan_en);

endmodule

// File: tb/fzs_fan_selector_tb_top.sv
`timescale 1ns/1ps
module fzs_fan_selector_tb_top;

    localparam int NCH  = 4;
    localparam int NLVL = 8;
    localparam int TW   = 8;
    localparam int DW   = 8;
    localparam int CW   = 16;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   conv_done = 1'b0;
    logic                   mode_rpm = 1'b0;
    logic [NCH*TW-1:0]      temp_in = '0;
    logic [NCH*NLVL*TW-1:0] thr_tab;
    logic [NCH*TW-1:0]      hyst_tab;
    logic [NCH*NLVL*DW-1:0] duty_tab;
    logic [NCH*NLVL*CW-1:0] tach_tab;
    logic [DW-1:0]          duty_out;
    logic [CW-1:0]          tach_target;
    logic                   fan_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int lv [NCH];
    int exp_duty;
    int exp_tach;
    int exp_en;

    always #10 clk = ~clk;

    fzs_fan_selector #(.NCH(NCH), .NLVL(NLVL), .TW(TW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .conv_done(conv_done), .mode_rpm(mode_rpm),
        .temp_in(temp_in), .thr_tab(thr_tab), .hyst_tab(hyst_tab),
        .duty_tab(duty_tab), .tach_tab(tach_tab),
        .duty_out(duty_out), .tach_target(tach_target), .fan_en(fan_en)
    );

    function automatic int thr_v(int ch, int k);  return 40 + ch*3 + k*20;  endfunction
    function automatic int hyst_v(int ch);        return ch + 2;            endfunction
    function automatic int duty_v(int ch, int k); return 20 + k*30 + ch;    endfunction
    function automatic int tach_v(int ch, int k); return 4000 - k*400 - ch*10; endfunction

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    // model one conversion from the requirements
    task automatic model(input int t [NCH]);
        int best_d;
        int best_t;
        bit any;
        any = 0;
        best_d = 0;
        best_t = 65535;
        for (int ch = 0; ch < NCH; ch++) begin
            int l;
            l = lv[ch];
            if (l < NLVL && t[ch] >= thr_v(ch, l)) begin
                while (l < NLVL && t[ch] >= thr_v(ch, l)) l++;
            end else begin
                while (l > 0 && t[ch] < thr_v(ch, l-1) - hyst_v(ch)) l--;
            end
            lv[ch] = l;
            if (l > 0) begin
                any = 1;
                if (duty_v(ch, l-1) > best_d) best_d = duty_v(ch, l-1);
                if (tach_v(ch, l-1) < best_t) best_t = tach_v(ch, l-1);
            end
        end
        if (!any) begin
            exp_duty = 0;
            exp_en   = 0;
        end else begin
            exp_en = 1;
            if (mode_rpm) exp_tach = best_t;
            else          exp_duty = best_d;
        end
    endtask

    task automatic check_outs(input string phase);
        check(int'(duty_out) == exp_duty,
              !exp_en ? {"R7 duty off ", phase} : (mode_rpm ? {"R6 duty rpm ", phase} : {"R4 duty max ", phase}),
              int'(duty_out), exp_duty);
        check(int'(tach_target) == exp_tach,
              mode_rpm ? {"R5 tach min ", phase} : {"R4 tach hold ", phase},
              int'(tach_target), exp_tach);
        check(int'(fan_en) == exp_en,
              exp_en ? {"R8 enable ", phase} : {"R7 disable ", phase},
              int'(fan_en), exp_en);
    endtask

    task automatic convert(input int t [NCH], input string phase);
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) temp_in[ch*TW +: TW] = TW'(t[ch]);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        model(t);
        check_outs(phase);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int ch = 0; ch < NCH; ch++) lv[ch] = 0;
        exp_duty = 0;
        exp_tach = 65535;
        exp_en   = 0;
        check_outs("R9 reset");
    endtask

    task automatic ramps(input string tag);
        int t [NCH];
        for (int v = 0; v < 256; v++) begin
            for (int ch = 0; ch < NCH; ch++) t[ch] = v;
            convert(t, {tag, " R2 ramp up"});
        end
        for (int v = 255; v >= 0; v--) begin
            for (int ch = 0; ch < NCH; ch++) t[ch] = v;
            convert(t, {tag, " R3 ramp down"});
        end
        // staggered single-channel ramp: merge between channels
        for (int v = 0; v < 256; v += 3) begin
            for (int ch = 0; ch < NCH; ch++) t[ch] = (v + ch*61) % 256;
            convert(t, {tag, " R4 staggered"});
        end
    endtask

    task automatic mixes(input string tag, input int n);
        logic [15:0] lfsr;
        int t [NCH];
        lfsr = 16'hACE1;
        for (int i = 0; i < n; i++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                t[ch] = int'(lfsr[7:0]);
            end
            convert(t, {tag, " R10 mix"});
        end
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            hyst_tab[ch*TW +: TW] = TW'(hyst_v(ch));
            for (int k = 0; k < NLVL; k++) begin
                thr_tab [(ch*NLVL+k)*TW +: TW] = TW'(thr_v(ch, k));
                duty_tab[(ch*NLVL+k)*DW +: DW] = DW'(duty_v(ch, k));
                tach_tab[(ch*NLVL+k)*CW +: CW] = CW'(tach_v(ch, k));
            end
        end
    end

    initial begin
        int t [NCH];
        do_reset();

        // direct mode
        mode_rpm = 1'b0;
        ramps("direct");
        for (int ch = 0; ch < NCH; ch++) t[ch] = 0;
        convert(t, "R7 all cold");
        for (int ch = 0; ch < NCH; ch++) t[ch] = 0;
        t[2] = 250;
        convert(t, "R10 jump to top");
        check(int'(duty_out) == duty_v(2, NLVL-1), "R10 top entry", int'(duty_out), duty_v(2, NLVL-1));
        t[2] = 0;
        convert(t, "R10 jump to off");
        mixes("direct", 300);

        // R1: temperatures move but no strobe
        begin
            int d0, c0, e0;
            d0 = int'(duty_out); c0 = int'(tach_target); e0 = int'(fan_en);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                temp_in = (i % 2 == 0) ? '1 : '0;
            end
            @(negedge clk);
            check(int'(duty_out) == d0,    "R1 duty hold", int'(duty_out), d0);
            check(int'(tach_target) == c0, "R1 tach hold", int'(tach_target), c0);
            check(int'(fan_en) == e0,      "R1 en hold", int'(fan_en), e0);
        end

        // closed-loop mode
        mode_rpm = 1'b1;
        ramps("rpm");
        mixes("rpm", 300);

        // reset mid-run clears levels
        for (int ch = 0; ch < NCH; ch++) t[ch] = 200;
        convert(t, "R5 hot before reset");
        do_reset();
        mode_rpm = 1'b0;
        for (int ch = 0; ch < NCH; ch++) t[ch] = 30;
        t[0] = 45;
        convert(t, "R9 levels cleared");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule